// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

The block drives the fetch side of a transmit DMA channel. Software builds a circular ring of two-word descriptors in memory: a flag word and a buffer address word. It hands descriptors to hardware by setting their ownership bit, then writes a one-bit kick command. The engine reads each hardware-owned descriptor through a simple memory port with one cycle of read latency. For each one it presents a buffer request to a downstream data mover. When the mover reports completion, the engine writes the flag word back with ownership returned to software and steps to the next ring slot.

The walk ends at the first descriptor that software owns. At that point the block raises a one-cycle "all done" pulse. Depending on a mode bit, the pulse comes either at once or only after the downstream FIFO reports empty. A second pulse reports each completed descriptor. A third reports a packet whose descriptors were not closed by an end-of-packet descriptor.

Top module: `txd_ring_walker`

## Requirements
- R1: Writing a 1 to bit 0 of register select 0 sets a pending kick, which reads back as bit 0 of that register. While the enable bit (register select 1, bit 0) is 0, the kick stays pending. Once the engine is enabled and idle, it accepts the kick and the bit reads 0 again.
- R2: The ring pointer (register select 2) holds a 21-bit base in bits 28..8 and an 8-bit slot index in bits 7..0. The flag word of the current slot is fetched at byte address {base, index, 3'b000}, and the address word at that address plus 4.
- R3: For a flag word with bit 31 set, the engine presents `bufValid` and holds it until `bufReady`. The request carries the following fields, unchanged while it waits:
  - `bufAddr` from the address word;
  - `bufLen` from flag bits 13..0;
  - `bufCsStart` from bits 19..14;
  - `bufCsStuff` from bits 27..20;
  - `bufCsEn` from bit 28;
  - `bufEop` from bit 29;
  - `bufSop` from bit 30.
- R4: After `moverDone`, the engine writes the flag word back to its own address with bit 31 cleared and all other bits unchanged. It then pulses `descDone` for one cycle.
- R5: Register select 3 holds a 4-bit ring size N, which gives a ring of (N+1)*16 slots. After a write-back, the index advances by one. From slot (N+1)*16-1 it wraps to 0, and the base bits stay unchanged.
- R6: A fetched flag word with bit 31 clear ends the walk with no buffer request. With the drain-mode bit (register select 1, bit 10) at 0, `allDone` pulses once at that point.
- R7: With the drain-mode bit at 1, the engine does not pulse `allDone` when the walk ends. It waits, and pulses only after `fifoEmpty` is high.
- R8: `eopErr` pulses once in two cases. The first is a hardware-owned descriptor with its start flag set that arrives while the previous packet is still open (no end flag seen yet). The second is a walk that ends while a packet is open.
- R9: While the enable bit is 0, the engine issues no memory request and accepts no kick.
- R10: After reset, all four registers read 0 and `bufValid`, `memReq`, `descDone`, `allDone` and `eopErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 kick, 1 config, 2 ring pointer, 3 ring size |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid the cycle after a read request |
| bufValid | output | 1 | Buffer request valid |
| bufReady | input | 1 | Mover accepts the request |
| bufAddr | output | 32 | Buffer address |
| bufLen | output | 14 | Buffer byte count |
| bufSop | output | 1 | Start of packet |
| bufEop | output | 1 | End of packet |
| bufCsEn | output | 1 | Checksum enable |
| bufCsStuff | output | 8 | Checksum stuff offset |
| bufCsStart | output | 6 | Checksum start offset |
| moverDone | input | 1 | Mover completion pulse for the accepted request |
| fifoEmpty | input | 1 | Downstream FIFO is empty |
| descDone | output | 1 | One-cycle pulse per descriptor returned |
| allDone | output | 1 | One-cycle pulse at end of walk |
| eopErr | output | 1 | One-cycle pulse on an unterminated packet |

## Verification
The bench builds the block with its default parameters: an 8-bit slot index, a 21-bit base and a 4-bit ring size in steps of 16. With these values both the smallest ring (16 slots) and the largest (256 slots) are reached by a single register write. This lets the bench check the wrap at slot 15 and at slot 255, and check that slot 15 does not wrap in the 256-slot ring. A non-zero base shows that the base bits stay unchanged across every fetch and wrap.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int FLAG_OWN  = 31;
  localparam int FLAG_SOP  = 30;
  localparam int FLAG_EOP  = 29;
  localparam int FLAG_CSEN = 28;
  localparam int STUFF_LSB = 20;
  localparam int START_LSB = 14;
  localparam int LEN_W     = 14;
  localparam int THR_W     = 9;

  typedef enum logic [1:0] {
    SEL_KICK = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_SIZE = 2'd3
  } regSel_t;

  typedef struct packed {
    logic kickTake;
    logic memRd;
    logic addrWord;
    logic capFlags;
    logic capAddr;
    logic writeBack;
    logic advance;
  } ctlStrobe_t;
endpackage

// File: rtl/txd_datapath.sv
module txd_datapath
  import txd_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int BASE_W   = 21,
  parameter int SIZE_W   = 4,
  parameter int STEP_LOG = 4,
  localparam int PTR_W   = BASE_W + IDX_W,
  localparam int ADDR_W  = PTR_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [31:0]       memRdata,
  input  ctlStrobe_t        st,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              kickPend,
  output logic              cfgEnable,
  output logic              cfgDrain,
  output logic              rdOwn,
  output logic [31:0]       bufAddr,
  output logic [LEN_W-1:0]  bufLen,
  output logic              bufSop,
  output logic              bufEop,
  output logic              bufCsEn,
  output logic [7:0]        bufCsStuff,
  output logic [5:0]        bufCsStart,
  output logic              eopErr
);
  logic [THR_W-1:0]  cfgThresh;
  logic [BASE_W-1:0] ptrBase;
  logic [IDX_W-1:0]  ptrIdx;
  logic [SIZE_W-1:0] sizeReg;
  logic [31:0]       flagsQ;
  logic [31:0]       addrQ;
  logic              pktOpen;
  logic              eopErrQ;
  logic [IDX_W:0]    ringEntries;
  logic [IDX_W:0]    lastIdxW;
  logic [IDX_W-1:0]  lastIdx;
  logic              unusedWr;

  assign unusedWr    = ^regWrData[31:PTR_W];
  assign ringEntries = ({{(IDX_W + 1 - SIZE_W){1'b0}}, sizeReg} + 1'b1) << STEP_LOG;
  assign lastIdxW    = ringEntries - 1'b1;
  assign lastIdx     = lastIdxW[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kickPend  <= 1'b0;
      cfgEnable <= 1'b0;
      cfgThresh <= '0;
      cfgDrain  <= 1'b0;
      ptrBase   <= '0;
      ptrIdx    <= '0;
      sizeReg   <= '0;
    end else begin
      if (regWrEn && regAddr == SEL_KICK && regWrData[0]) kickPend <= 1'b1;
      else if (st.kickTake)                               kickPend <= 1'b0;
      if (regWrEn && regAddr == SEL_CFG) begin
        cfgEnable <= regWrData[0];
        cfgThresh <= regWrData[THR_W:1];
        cfgDrain  <= regWrData[THR_W+1];
      end
      if (regWrEn && regAddr == SEL_SIZE) sizeReg <= regWrData[SIZE_W-1:0];
      if (regWrEn && regAddr == SEL_PTR) begin
        ptrBase <= regWrData[PTR_W-1:IDX_W];
        ptrIdx  <= regWrData[IDX_W-1:0];
      end else if (st.advance) begin
        ptrIdx <= (ptrIdx == lastIdx) ? '0 : ptrIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ  <= '0;
      addrQ   <= '0;
      pktOpen <= 1'b0;
      eopErrQ <= 1'b0;
    end else begin
      eopErrQ <= 1'b0;
      if (st.capFlags) begin
        if (memRdata[FLAG_OWN]) begin
          flagsQ  <= memRdata;
          eopErrQ <= pktOpen & memRdata[FLAG_SOP];
          pktOpen <= ~memRdata[FLAG_EOP];
        end else begin
          eopErrQ <= pktOpen;
          pktOpen <= 1'b0;
        end
      end
      if (st.capAddr) addrQ <= memRdata;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regSel_t'(regAddr))
      SEL_KICK: regRdData[0]             = kickPend;
      SEL_CFG:  regRdData[THR_W+1:0]     = {cfgDrain, cfgThresh, cfgEnable};
      SEL_PTR:  regRdData[PTR_W-1:0]     = {ptrBase, ptrIdx};
      SEL_SIZE: regRdData[SIZE_W-1:0]    = sizeReg;
      default:  regRdData                = '0;
    endcase
  end

  assign memAddr    = {ptrBase, ptrIdx, st.addrWord, 2'b00};
  assign memWdata   = flagsQ & ~(32'd1 << FLAG_OWN);
  assign rdOwn      = memRdata[FLAG_OWN];
  assign bufAddr    = addrQ;
  assign bufLen     = flagsQ[LEN_W-1:0];
  assign bufCsStart = flagsQ[START_LSB +: 6];
  assign bufCsStuff = flagsQ[STUFF_LSB +: 8];
  assign bufCsEn    = flagsQ[FLAG_CSEN];
  assign bufEop     = flagsQ[FLAG_EOP];
  assign bufSop     = flagsQ[FLAG_SOP];
  assign eopErr     = eopErrQ;
endmodule

// File: rtl/txd_control.sv
module txd_control
  import txd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       kickPend,
  input  logic       cfgEnable,
  input  logic       cfgDrain,
  input  logic       rdOwn,
  input  logic       bufReady,
  input  logic       moverDone,
  input  logic       fifoEmpty,
  output ctlStrobe_t st,
  output logic       memReq,
  output logic       memWe,
  output logic       bufValid,
  output logic       descDone,
  output logic       allDone
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_LOADADDR, S_ISSUE, S_WAITDONE, S_WRBACK, S_DRAIN
  } walkState_t;

  walkState_t state, nextState;
  logic       descDoneSet, allDoneSet;

  always_comb begin
    st          = '0;
    nextState   = state;
    descDoneSet = 1'b0;
    allDoneSet  = 1'b0;
    unique case (state)
      S_IDLE: if (kickPend && cfgEnable) begin
        st.kickTake = 1'b1;
        nextState   = S_FETCH;
      end
      S_FETCH: if (!cfgEnable) nextState = S_IDLE;
        else begin
          st.memRd  = 1'b1;
          nextState = S_CHECK;
        end
      S_CHECK: begin
        st.capFlags = 1'b1;
        if (rdOwn) begin
          st.memRd    = 1'b1;
          st.addrWord = 1'b1;
          nextState   = S_LOADADDR;
        end else if (cfgDrain) begin
          nextState = S_DRAIN;
        end else begin
          allDoneSet = 1'b1;
          nextState  = S_IDLE;
        end
      end
      S_LOADADDR: begin
        st.capAddr = 1'b1;
        nextState  = S_ISSUE;
      end
      S_ISSUE:    if (bufReady)  nextState = S_WAITDONE;
      S_WAITDONE: if (moverDone) nextState = S_WRBACK;
      S_WRBACK: begin
        st.writeBack = 1'b1;
        st.advance   = 1'b1;
        descDoneSet  = 1'b1;
        nextState    = S_FETCH;
      end
      S_DRAIN: if (fifoEmpty) begin
        allDoneSet = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      descDone <= 1'b0;
      allDone  <= 1'b0;
    end else begin
      state    <= nextState;
      descDone <= descDoneSet;
      allDone  <= allDoneSet;
    end
  end

  assign memReq   = st.memRd | st.writeBack;
  assign memWe    = st.writeBack;
  assign bufValid = (state == S_ISSUE);
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
  import txd_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int BASE_W   = 21,
  parameter int SIZE_W   = 4,
  parameter int STEP_LOG = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic [1:0]                  regAddr,
  input  logic [31:0]                 regWrData,
  output logic [31:0]                 regRdData,
  output logic                        memReq,
  output logic                        memWe,
  output logic [BASE_W+IDX_W+2:0]     memAddr,
  output logic [31:0]                 memWdata,
  input  logic [31:0]                 memRdata,
  output logic                        bufValid,
  input  logic                        bufReady,
  output logic [31:0]                 bufAddr,
  output logic [13:0]                 bufLen,
  output logic                        bufSop,
  output logic                        bufEop,
  output logic                        bufCsEn,
  output logic [7:0]                  bufCsStuff,
  output logic [5:0]                  bufCsStart,
  input  logic                        moverDone,
  input  logic                        fifoEmpty,
  output logic                        descDone,
  output logic                        allDone,
  output logic                        eopErr
);
  ctlStrobe_t st;
  logic       kickPend, cfgEnable, cfgDrain, rdOwn;

  txd_datapath #(
    .IDX_W(IDX_W), .BASE_W(BASE_W), .SIZE_W(SIZE_W), .STEP_LOG(STEP_LOG)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memRdata(memRdata), .st(st), .memAddr(memAddr), .memWdata(memWdata),
    .kickPend(kickPend), .cfgEnable(cfgEnable), .cfgDrain(cfgDrain), .rdOwn(rdOwn),
    .bufAddr(bufAddr), .bufLen(bufLen), .bufSop(bufSop), .bufEop(bufEop),
    .bufCsEn(bufCsEn), .bufCsStuff(bufCsStuff), .bufCsStart(bufCsStart),
    .eopErr(eopErr)
  );

  txd_control u_ctl (
    .clk(clk), .rstN(rstN),
    .kickPend(kickPend), .cfgEnable(cfgEnable), .cfgDrain(cfgDrain), .rdOwn(rdOwn),
    .bufReady(bufReady), .moverDone(moverDone), .fifoEmpty(fifoEmpty),
    .st(st), .memReq(memReq), .memWe(memWe), .bufValid(bufValid),
    .descDone(descDone), .allDone(allDone)
  );
endmodule

// File: rtl/txd_ring_walker_chk.sv
module txd_ring_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              bufValid,
  input logic              bufReady,
  input logic [31:0]       bufAddr,
  input logic [13:0]       bufLen,
  input logic              descDone,
  input logic              allDone,
  input logic              cfgDrain,
  input logic              fifoEmpty
);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    bufValid && !bufReady |=> bufValid && $stable(bufAddr) && $stable(bufLen));

  a_r3_no_mem_during_req: assert property (@(posedge clk) disable iff (!rstN)
    bufValid |-> !memReq);

  a_r4_wb_own_clear: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !memWdata[31] && !memAddr[2]);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    descDone |=> !descDone);

  a_r6_alldone_single: assert property (@(posedge clk) disable iff (!rstN)
    allDone |=> !allDone);

  a_r7_drain_gate: assert property (@(posedge clk) disable iff (!rstN)
    allDone && cfgDrain |-> $past(fifoEmpty));
endmodule

bind txd_ring_walker txd_ring_walker_chk #(.ADDR_W(BASE_W + IDX_W + 3)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .bufValid(bufValid), .bufReady(bufReady), .bufAddr(bufAddr),
  .bufLen(bufLen), .descDone(descDone), .allDone(allDone), .cfgDrain(cfgDrain),
  .fifoEmpty(fifoEmpty)
);

// File: tb/tb_txd_ring_walker.sv
module tb_txd_ring_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata;
  logic        bufValid;
  logic        bufReady = 1'b1;
  logic [31:0] bufAddr;
  logic [13:0] bufLen;
  logic        bufSop, bufEop, bufCsEn;
  logic [7:0]  bufCsStuff;
  logic [5:0]  bufCsStart;
  logic        moverDone = 1'b0;
  logic        fifoEmpty = 1'b1;
  logic        descDone, allDone, eopErr;

  int checks = 0;
  int errors = 0;
  int descCnt = 0, allCnt = 0, errCnt = 0, memReqCnt = 0, baseBad = 0;
  logic [20:0] expBase = 21'h0ABCD;

  logic        pokeWr = 1'b0;
  logic [8:0]  pokeIdx = '0;
  logic [31:0] pokeData = '0;
  logic [31:0] mem [512];

  always #10 clk = ~clk;

  txd_ring_walker dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .bufValid(bufValid), .bufReady(bufReady),
    .bufAddr(bufAddr), .bufLen(bufLen), .bufSop(bufSop), .bufEop(bufEop),
    .bufCsEn(bufCsEn), .bufCsStuff(bufCsStuff), .bufCsStart(bufCsStart),
    .moverDone(moverDone), .fifoEmpty(fifoEmpty), .descDone(descDone),
    .allDone(allDone), .eopErr(eopErr)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 512; i++) mem[i] <= '0;
      memRdata <= '0;
    end else begin
      if (pokeWr) mem[pokeIdx] <= pokeData;
      else if (memReq && memWe) mem[memAddr[10:2]] <= memWdata;
      if (memReq && !memWe) memRdata <= mem[memAddr[10:2]];
    end
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (descDone) descCnt <= descCnt + 1;
      if (allDone) allCnt <= allCnt + 1;
      if (eopErr) errCnt <= errCnt + 1;
      if (memReq) memReqCnt <= memReqCnt + 1;
      if (memReq && memAddr[31:11] != expBase) baseBad <= baseBad + 1;
    end
  end

  // {own,sop,eop,csen,stuff[7:0],start[5:0],len[13:0], bufferAddress[31:0]}
  localparam logic [63:0] TBL [6] = '{
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h22, 6'h0E, 14'd64,   32'h1000_0000},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 6'h00, 14'd100,  32'h1000_1003},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h5A, 6'h15, 14'h3FFF, 32'hDEAD_BEEF},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 6'h3F, 14'd1,    32'h0000_0000},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h10, 6'h22, 14'd1500, 32'h8000_0008},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h01, 6'h01, 14'd8,    32'h7FFF_FFF8}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic poke(input int idx, input logic [31:0] d);
    @(negedge clk);
    pokeWr = 1'b1; pokeIdx = 9'(idx); pokeData = d;
    @(negedge clk);
    pokeWr = 1'b0;
  endtask

  task automatic putDesc(input int slot, input logic [31:0] flags, input logic [31:0] addr);
    poke(2 * slot, flags);
    poke(2 * slot + 1, addr);
  endtask

  task automatic waitBuf(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (bufValid) seen = 1'b1;
    end
  endtask

  task automatic finishMover();
    @(negedge clk);
    @(negedge clk);
    moverDone = 1'b1;
    @(negedge clk);
    moverDone = 1'b0;
  endtask

  task automatic waitAll(input int target);
    for (int i = 0; i < 300 && allCnt < target; i++) @(negedge clk);
  endtask

  task automatic kick();
    regWrite(2'd0, 32'd1);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit seen;
    int base0;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), rd);
      check(rd == 32'd0, "R10 register reset", rd, 0);
    end
    check(!bufValid && !memReq && !descDone && !allDone && !eopErr, "R10 outputs idle",
          {bufValid, memReq, descDone, allDone, eopErr}, 0);

    // Main walk, 16-slot ring, walked from the table
    for (int i = 0; i < 6; i++) putDesc(i, TBL[i][63:32], TBL[i][31:0]);
    putDesc(6, 32'h0, 32'h0);
    regWrite(2'd3, 32'd0);
    regWrite(2'd2, {3'b0, expBase, 8'd0});
    regWrite(2'd1, 32'h1);
    kick();
    for (int i = 0; i < 6; i++) begin
      waitBuf(seen);
      check(seen, "R3 request presented", 64'(seen), 1);
      check(bufAddr == TBL[i][31:0], "R2 address word", bufAddr, TBL[i][31:0]);
      check({bufSop, bufEop, bufCsEn, bufCsStuff, bufCsStart, bufLen} == TBL[i][62:32],
            "R3 request fields", {bufSop, bufEop, bufCsEn, bufCsStuff, bufCsStart, bufLen},
            TBL[i][62:32]);
      finishMover();
    end
    waitAll(1);
    check(allCnt == 1, "R6 all-done after walk", allCnt, 1);
    check(descCnt == 6, "R4 descriptor pulses", descCnt, 6);
    check(errCnt == 1, "R8 walk ended with open packet", errCnt, 1);
    for (int i = 0; i < 6; i++)
      check(mem[2 * i] == (TBL[i][63:32] & 32'h7FFF_FFFF), "R4 write-back flags",
            mem[2 * i], TBL[i][63:32] & 32'h7FFF_FFFF);
    regRead(2'd2, rd);
    check(rd == {3'b0, expBase, 8'd6}, "R5 index advance", rd, {3'b0, expBase, 8'd6});

    // R8: start flag while a packet is open
    putDesc(6, 32'hC000_0010, 32'h100);
    putDesc(7, 32'hE000_0010, 32'h200);
    putDesc(8, 32'h0, 32'h0);
    kick();
    for (int i = 0; i < 2; i++) begin waitBuf(seen); finishMover(); end
    waitAll(2);
    check(errCnt == 2, "R8 start flag inside open packet", errCnt, 2);
    check(allCnt == 2, "R6 second walk end", allCnt, 2);

    // R5: wrap at slot 15 in a 16-slot ring
    putDesc(15, 32'hE000_0004, 32'h300);
    regWrite(2'd2, {3'b0, expBase, 8'd15});
    kick();
    waitBuf(seen); finishMover();
    waitAll(3);
    regRead(2'd2, rd);
    check(rd == {3'b0, expBase, 8'd0}, "R5 wrap 16-slot ring", rd, {3'b0, expBase, 8'd0});

    // R5: wrap at slot 255 in a 256-slot ring
    regWrite(2'd3, 32'd15);
    putDesc(255, 32'hE000_0004, 32'h400);
    regWrite(2'd2, {3'b0, expBase, 8'd255});
    kick();
    waitBuf(seen); finishMover();
    waitAll(4);
    regRead(2'd2, rd);
    check(rd == {3'b0, expBase, 8'd0}, "R5 wrap 256-slot ring", rd, {3'b0, expBase, 8'd0});

    // R5: slot 15 does not wrap in the 256-slot ring
    putDesc(15, 32'hE000_0004, 32'h500);
    putDesc(16, 32'h0, 32'h0);
    regWrite(2'd2, {3'b0, expBase, 8'd15});
    kick();
    waitBuf(seen); finishMover();
    waitAll(5);
    regRead(2'd2, rd);
    check(rd == {3'b0, expBase, 8'd16}, "R5 no early wrap", rd, {3'b0, expBase, 8'd16});
    check(baseBad == 0, "R2 base bits on every access", baseBad, 0);

    // R7: drain mode waits for the FIFO
    fifoEmpty = 1'b0;
    regWrite(2'd1, 32'h401);
    kick();
    repeat (20) @(negedge clk);
    check(allCnt == 5, "R7 held while FIFO busy", allCnt, 5);
    fifoEmpty = 1'b1;
    waitAll(6);
    check(allCnt == 6, "R7 fires once FIFO empty", allCnt, 6);

    // R9 / R1: disabled engine ignores the kick
    regWrite(2'd1, 32'h0);
    base0 = memReqCnt;
    kick();
    repeat (20) @(negedge clk);
    check(memReqCnt == base0, "R9 no memory access when disabled", memReqCnt, base0);
    regRead(2'd0, rd);
    check(rd == 32'd1, "R1 kick pending while disabled", rd, 1);
    check(allCnt == 6, "R9 no walk when disabled", allCnt, 6);
    regWrite(2'd1, 32'h1);
    repeat (3) @(negedge clk);
    regRead(2'd0, rd);
    check(rd == 32'd0, "R1 kick self-clears", rd, 0);
    waitAll(7);
    check(allCnt == 7, "R6 empty walk signals", allCnt, 7);
    check(descCnt == 11, "R4 total descriptor pulses", descCnt, 11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule